// File: doc/BRIEF.md
# LZSS Decoder Codeword Sequencer

This block sits between the bit-stream front end of an LZSS decompressor and its dictionary copy logic. It accepts one decoded codeword at a time. A codeword is either a literal character or a back-reference made of an offset and a match length. The block turns each codeword into a steady run of per-character commands, one command per output cycle. A literal yields one cycle in which the character is presented. A back-reference yields as many consecutive copy cycles as its length, with the offset held steady throughout.

Codewords arrive on a valid/ready stream whose rate varies. A down counter tracks the remaining cycles of the codeword being expanded. The block opens its input during the final output cycle of the current codeword, so consecutive codewords run back to back with no idle cycle. After reset, a short priming sequence keeps the input closed while the front end fills its registers.

The command side carries its own back-pressure input. When the copy logic holds `out_ready` low, the current command is repeated and nothing advances. When no codeword is waiting, both command strobes stay low and the offset and character outputs keep their last values.

Top module: `lzss_cw_sequencer`

## Requirements
- R1: After reset is released, `cw_ready`, `copy_act` and `lit_act` stay low for exactly PRIME_STEPS (default 3) clock edges. `cw_ready` goes high on the cycle after the third edge if no codeword is in progress.
- R2: A codeword is taken on a rising edge where `cw_valid` and `cw_ready` are both high. `cw_ptr`=1 marks a back-reference, using `cw_len` and `cw_off`. `cw_ptr`=0 marks a literal, using `cw_chr`.
- R3: A back-reference of length L≥1 drives `copy_act` high for exactly L output cycles. These begin in the cycle after acceptance, and `out_off` equals the accepted offset in every one of them.
- R4: A literal drives `lit_act` high for exactly one output cycle, in the cycle after acceptance, with `out_chr` equal to the accepted character.
- R5: While a codeword is being expanded, `cw_ready` is high only in its last output cycle, and only when `out_ready` is high. A waiting codeword therefore starts in the very next cycle, with no gap. A back-reference of length 1 follows the same timing as a literal.
- R6: A back-reference with `cw_len`=0 produces no output cycle. `cw_ready` stays high in the cycle after it is accepted.
- R7: When no codeword is in progress and `cw_valid` is low, `copy_act` and `lit_act` stay low, and `out_off` and `out_chr` hold their previous values.
- R8: While `out_ready` is low during an output cycle, that cycle repeats with the same strobe, offset and character, and `cw_ready` is low.
- R9: `copy_act` and `lit_act` are never high in the same cycle.
- R10: During reset, all outputs are low and `out_off` and `out_chr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cw_valid | input | 1 | Codeword present on the input fields |
| cw_ready | output | 1 | Sequencer takes the codeword on this edge (request to front end) |
| cw_ptr | input | 1 | 1 = back-reference, 0 = literal |
| cw_len | input | LEN_W | Match length of a back-reference |
| cw_off | input | OFF_W | Match offset of a back-reference |
| cw_chr | input | CHR_W | Literal character |
| out_ready | input | 1 | Copy logic accepts the current command |
| copy_act | output | 1 | Copy one character from the dictionary at `out_off` |
| lit_act | output | 1 | Emit `out_chr` as a literal |
| out_off | output | OFF_W | Offset of the current back-reference |
| out_chr | output | CHR_W | Character of the current literal |

## Verification
The delicate cycle is the last output cycle of a codeword. In that cycle the counter's final decrement and the loading of the next codeword fall on the same edge, and a stall on `out_ready` can arrive at the same moment. The bench provokes this with back-to-back literals, length-1 and longer back-references offered with `cw_valid` held high, and random `out_ready` drops that land on final cycles. A behavioural model built from queued codewords and an integer run count predicts `cw_ready` and both strobes in every cycle. It flags any bubble, any overlap, and any codeword taken while a stall holds the last command.

// File: rtl/lzss_seq_pkg.sv
package lzss_seq_pkg;
  typedef enum logic {
    KIND_LIT = 1'b0,
    KIND_PTR = 1'b1
  } cw_kind_e;

  localparam int DEF_LEN_W  = 8;
  localparam int DEF_OFF_W  = 12;
  localparam int DEF_CHR_W  = 8;
  localparam int DEF_PRIME  = 3;
endpackage

// File: rtl/lzd_prime_seq.sv
module lzd_prime_seq #(
  parameter int STEPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS);

  logic [CW-1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              step_q <= '0;
    else if (step_q != LAST) step_q <= step_q + 1'b1;
  end

  assign done = (step_q == LAST);

  AST_PRIME_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R1
endmodule

// File: rtl/lzd_run_ctr.sv
module lzd_run_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             advance,
  output logic             busy,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= load_val;
    else if (advance) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == LEN_W'(1));

  AST_RUN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (cnt_q == LEN_W'($past(cnt_q) - 1))); // R3
  AST_RUN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/lzss_cw_sequencer.sv
module lzss_cw_sequencer
  import lzss_seq_pkg::*;
#(
  parameter int LEN_W       = DEF_LEN_W,
  parameter int OFF_W       = DEF_OFF_W,
  parameter int CHR_W       = DEF_CHR_W,
  parameter int PRIME_STEPS = DEF_PRIME
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cw_valid,
  output logic             cw_ready,
  input  logic             cw_ptr,
  input  logic [LEN_W-1:0] cw_len,
  input  logic [OFF_W-1:0] cw_off,
  input  logic [CHR_W-1:0] cw_chr,
  input  logic             out_ready,
  output logic             copy_act,
  output logic             lit_act,
  output logic [OFF_W-1:0] out_off,
  output logic [CHR_W-1:0] out_chr
);
  localparam logic [LEN_W-1:0] ONE_RUN = LEN_W'(1);

  logic             prime_done;
  logic             run_busy;
  logic             run_last;
  logic             take;
  logic             advance;
  logic [LEN_W-1:0] run_len;
  cw_kind_e         kind_q;
  logic [OFF_W-1:0] off_q;
  logic [CHR_W-1:0] chr_q;

  lzd_prime_seq #(.STEPS(PRIME_STEPS)) u_prime (
    .clk  (clk),
    .rst_n(rst_n),
    .done (prime_done)
  );

  // Input opens when idle, or in the final command cycle that is being consumed.
  assign cw_ready = prime_done && (!run_busy || (run_last && out_ready));
  assign take     = cw_valid && cw_ready;
  assign advance  = run_busy && out_ready;
  assign run_len  = cw_ptr ? cw_len : ONE_RUN;

  lzd_run_ctr #(.LEN_W(LEN_W)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .load_val(run_len),
    .advance (advance),
    .busy    (run_busy),
    .last    (run_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_LIT;
      off_q  <= '0;
      chr_q  <= '0;
    end else if (take) begin
      kind_q <= cw_ptr ? KIND_PTR : KIND_LIT;
      off_q  <= cw_off;
      chr_q  <= cw_chr;
    end
  end

  assign copy_act = run_busy && (kind_q == KIND_PTR);
  assign lit_act  = run_busy && (kind_q == KIND_LIT);
  assign out_off  = off_q;
  assign out_chr  = chr_q;

  AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !prime_done |-> (!copy_act && !lit_act)); // R1
  AST_KIND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(copy_act && lit_act)); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((copy_act || lit_act) && !out_ready) |=>
      ($stable(copy_act) && $stable(lit_act) && $stable(out_off) && $stable(out_chr))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy_act && !lit_act && !cw_valid) |=>
      (!copy_act && !lit_act && $stable(out_off) && $stable(out_chr))); // R7
  AST_LIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lit_act && out_ready && !cw_valid) |=> (!lit_act && !copy_act)); // R4
  AST_PTR_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && cw_ready && cw_ptr && (cw_len != '0)) |=> (copy_act && (out_off == $past(cw_off)))); // R3
endmodule

// File: tb/lzss_cw_sequencer_tb.sv
module lzss_cw_sequencer_tb;
  localparam int LEN_W = 8;
  localparam int OFF_W = 12;
  localparam int CHR_W = 8;
  localparam int PRIME = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cw_valid = 1'b0;
  logic             cw_ready;
  logic             cw_ptr = 1'b0;
  logic [LEN_W-1:0] cw_len = '0;
  logic [OFF_W-1:0] cw_off = '0;
  logic [CHR_W-1:0] cw_chr = '0;
  logic             out_ready = 1'b1;
  logic             copy_act, lit_act;
  logic [OFF_W-1:0] out_off;
  logic [CHR_W-1:0] out_chr;

  always #2.5 clk = ~clk;

  lzss_cw_sequencer #(.LEN_W(LEN_W), .OFF_W(OFF_W), .CHR_W(CHR_W), .PRIME_STEPS(PRIME)) u_dut (
    .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_ptr(cw_ptr), .cw_len(cw_len), .cw_off(cw_off), .cw_chr(cw_chr),
    .out_ready(out_ready), .copy_act(copy_act), .lit_act(lit_act),
    .out_off(out_off), .out_chr(out_chr));

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string tag = "R2";

  // behavioural reference: priming count, remaining run, held fields
  int          m_prime = 0;
  int          m_rem = 0;
  bit          m_ptr = 0;
  int unsigned m_off = 0;
  int unsigned m_chr = 0;
  int          bubbles = 0;

  task automatic chk(input string req, input string what, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Entered at a falling edge; leaves at the next falling edge.
  task automatic step(input bit v, input bit p, input int l, input int o, input int c, input bit ordy);
    bit e_ready, e_copy, e_lit, took;
    cw_valid = v; cw_ptr = p; cw_len = LEN_W'(l); cw_off = OFF_W'(o); cw_chr = CHR_W'(c);
    out_ready = ordy;
    #1;
    e_ready = (m_prime >= PRIME) && ((m_rem == 0) || (m_rem == 1 && ordy));
    e_copy  = (m_rem > 0) && m_ptr;
    e_lit   = (m_rem > 0) && !m_ptr;
    chk((m_prime < PRIME) ? "R1" : (m_rem > 0 ? "R5" : tag), "cw_ready", cw_ready, e_ready);
    chk((m_prime < PRIME) ? "R1" : tag, "copy_act", copy_act, e_copy);
    chk((m_prime < PRIME) ? "R1" : tag, "lit_act", lit_act, e_lit);
    chk(e_copy ? "R3" : tag, "out_off", out_off, m_off);
    chk(e_lit ? "R4" : tag, "out_chr", out_chr, m_chr);
    checks++;
    if (copy_act && lit_act) begin
      errors++;
      $display("FAIL R9 both strobes: actual=1 expected=0 at %0t", $time);
    end
    took = v && e_ready;
    @(posedge clk);
    if (m_prime < PRIME) m_prime++;
    if (took) begin
      m_ptr = p;
      m_off = o % (1 << OFF_W);
      m_chr = c % (1 << CHR_W);
      m_rem = p ? l : 1;
    end else if (m_rem > 0 && ordy) begin
      m_rem--;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10", "cw_ready", cw_ready, 0);
    chk("R10", "copy_act", copy_act, 0);
    chk("R10", "lit_act", lit_act, 0);
    chk("R10", "out_off", out_off, 0);
    chk("R10", "out_chr", out_chr, 0);
    rst_n = 1'b1;

    // R1: offered during priming, must not be taken; then R4 back-to-back literals
    tag = "R4";
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 8'h41 + i, 1);
    // R3 / R5: pointers of several lengths, input always offered
    tag = "R3";
    for (int n = 1; n <= 5; n++)
      for (int k = 0; k < n + 1; k++) step(1, 1, n, 100 + n, 0, 1);
    // R5: length-1 pointers interleaved with literals, no bubbles allowed
    tag = "R5";
    for (int i = 0; i < 10; i++) step(1, i % 2, 1, 200 + i, 8'h61 + i, 1);
    // R6: zero-length pointer is swallowed
    tag = "R6";
    step(1, 1, 0, 300, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    step(1, 1, 0, 301, 0, 1);
    step(1, 0, 0, 0, 8'h7a, 1);
    step(0, 0, 0, 0, 0, 1);
    // R7: idle with no input, outputs hold
    tag = "R7";
    for (int i = 0; i < 4; i++) step(0, 1, 3, 999, 99, 1);
    // R8: stalls, including on the last cycle of each codeword
    tag = "R8";
    step(1, 1, 3, 400, 0, 1);
    step(1, 0, 0, 0, 8'h30, 0);
    step(1, 0, 0, 0, 8'h30, 1);
    step(1, 0, 0, 0, 8'h30, 0);
    step(1, 0, 0, 0, 8'h30, 0);
    step(1, 0, 0, 0, 8'h30, 1);
    step(1, 0, 0, 0, 8'h31, 0);
    step(1, 0, 0, 0, 8'h31, 1);
    // R2: random mix of gaps, kinds, lengths and stalls
    tag = "R2";
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 6),
           $urandom_range(0, 4095), $urandom_range(0, 255), $urandom_range(0, 4) != 0);
    step(0, 0, 0, 0, 0, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule